// File: doc/BRIEF.md
# PHY Basic-Mode Control Register

This block holds the 16-bit basic-mode control word of a 10/100 Ethernet transceiver. A station manager reaches it through a plain parallel register port: a select line that marks an address match, a write enable, write data and read data. The serial management interface that would normally carry these accesses lives elsewhere. The block keeps the mode bits (loopback, speed, auto-negotiation enable, low power, isolate, duplex, collision test) and drives each one out as a level control toward the rest of the transceiver.

Two bits act as commands. Writing one to the top bit starts a software reset. The bit stays set for a fixed, parameterised number of cycles, and during that interval every write is dropped. When the interval ends, all mode bits are back at their defaults and the bit reads zero again. Writing one to the restart bit sends a one-cycle request to the auto-negotiation engine. The stored restart bit then clears, either when the engine acknowledges or after a single cycle, depending on a parameter. The isolate default comes from the strapped PHY address. A restore-defaults pulse tells the other management registers and state machines, which are kept outside this block, to return to their defaults.

All ports are plain control and status signals; there is no streaming data path and therefore no valid/ready handshake or back-pressure.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After the hardware reset is released, the register reads 0x3400 when the strap address is 0 and 0x3000 otherwise (speed 100 and auto-negotiation enable set, isolate set only for strap address 0), and the mode outputs match these values.
- R2: An accepted write with bit 15 at zero loads bits 14 (loopback), 13 (speed, 1 = 100 Mbps), 12 (auto-negotiation enable), 11 (low power), 10 (isolate), 8 (duplex, 1 = full) and 7 (collision test). The new values appear on read data and on the mode outputs in the cycle after the write.
- R3: Bits 6 to 0 always read zero, and writing ones to them has no effect.
- R4: An accepted write with bit 15 at one makes bit 15 read one for exactly RST_CYCLES cycles, starting in the cycle after the write. After that it reads zero.
- R5: A software reset puts every mode bit back to the R1 defaults, including the isolate default from the strap. It clears the restart bit and ignores all other bits of that write.
- R6: While bit 15 reads one, writes are dropped, and reads return the current value with bit 15 set.
- R7: An accepted write with bit 15 at zero and bit 9 at one raises an_restart_req for exactly the following cycle. A write with bit 9 at zero raises no request.
- R8: Bit 9 reads one from the cycle after the restart write. With WAIT_ACK=1 (default), it stays one until a cycle in which an_restart_ack is high and no new restart write is accepted, and reads zero in the cycle after that. With WAIT_ACK=0, it reads one for a single cycle.
- R9: restore_defaults is high while rst_n is low and in the first cycle after release. It is also high for the one cycle after an accepted software-reset write, and low otherwise.
- R10: A write with reg_sel or reg_wr_en low changes nothing.
- R11: reg_rd_data is zero whenever reg_sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| phy_addr_strap | input | 5 | Strapped PHY address, held static outside reset |
| reg_sel | input | 1 | Register address match |
| reg_wr_en | input | 1 | Write enable, qualified by reg_sel |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data, zero when not selected |
| loopback_en | output | 1 | Loopback mode |
| speed_100 | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| autoneg_en | output | 1 | Auto-negotiation enable |
| low_power | output | 1 | Low-power mode |
| isolate | output | 1 | Isolate from the MAC side |
| full_duplex | output | 1 | 1 = full duplex |
| col_test | output | 1 | Collision test enable |
| an_restart_req | output | 1 | One-cycle restart request to the auto-negotiation engine |
| an_restart_ack | input | 1 | Restart acknowledge (used when WAIT_ACK=1) |
| restore_defaults | output | 1 | Pulse telling other registers and state machines to reset |

## Verification
The assertions assume that the strap address changes only while rst_n is low. They also assume that reg_wr_en, reg_sel and an_restart_ack are synchronous levels sampled on the rising edge. They take no position on when acknowledges arrive, so an acknowledge with no request pending must be harmless. The stimulus changes the strap only inside a hardware-reset window and drives all inputs on the falling edge. It sends acknowledges at random, including while no restart is pending. It issues writes during the reset interval, so the dropped-write rule is exercised rather than avoided.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int RSVD_W = 7;

  localparam int B_SWRST  = 15;
  localparam int B_LOOP   = 14;
  localparam int B_SPEED  = 13;
  localparam int B_ANEN   = 12;
  localparam int B_LPWR   = 11;
  localparam int B_ISO    = 10;
  localparam int B_ANRST  = 9;
  localparam int B_DUPLEX = 8;
  localparam int B_COLT   = 7;

  typedef struct packed {
    logic loopback;
    logic speed_100;
    logic an_enable;
    logic low_power;
    logic isolate;
    logic full_duplex;
    logic col_test;
  } mode_t;

  function automatic mode_t mode_default(input logic [ADDR_W-1:0] strap);
    mode_t m;
    m = '0;
    m.speed_100 = 1'b1;
    m.an_enable = 1'b1;
    m.isolate   = (strap == '0);
    return m;
  endfunction

  function automatic mode_t mode_from_word(input logic [REG_W-1:0] w);
    mode_t m;
    m.loopback    = w[B_LOOP];
    m.speed_100   = w[B_SPEED];
    m.an_enable   = w[B_ANEN];
    m.low_power   = w[B_LPWR];
    m.isolate     = w[B_ISO];
    m.full_duplex = w[B_DUPLEX];
    m.col_test    = w[B_COLT];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] word_from_mode(input mode_t m, input logic swrst,
                                                      input logic anrst);
    return {swrst, m.loopback, m.speed_100, m.an_enable, m.low_power, m.isolate,
            anrst, m.full_duplex, m.col_test, {RSVD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/phy_mgmt_swrst.sv
module phy_mgmt_swrst #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int SPAN  = (RST_CYCLES > 1) ? RST_CYCLES : 2;
  localparam int CNT_W = $clog2(SPAN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (last_cycle) busy <= 1'b0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cycle) |=> busy);
  assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_cycle) |=> !busy);
endmodule

// File: rtl/phy_mgmt_anrst.sv
module phy_mgmt_anrst #(
  parameter bit WAIT_ACK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  input  logic ack,
  output logic bit_q,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= set && !clear;
  end

  generate
    if (WAIT_ACK) begin : g_wait_ack
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (clear) bit_q <= 1'b0;
        else if (set)   bit_q <= 1'b1;
        else if (ack)   bit_q <= 1'b0;
      end

      assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !ack && !clear) |=> bit_q);
    end else begin : g_one_cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= set && !clear;
      end

      assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !set) |=> !bit_q);
    end
  endgenerate

  assert_req_with_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> bit_q);
endmodule

// File: rtl/phy_mgmt_modes.sv
module phy_mgmt_modes
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap,
  input  logic              load_dflt,
  input  logic              wr,
  input  logic [REG_W-1:0]  wr_word,
  output mode_t             mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= mode_default(strap);
    else if (load_dflt) mode_q <= mode_default(strap);
    else if (wr)        mode_q <= mode_from_word(wr_word);
  end

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_dflt && !wr) |=> $stable(mode_q));
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter bit WAIT_ACK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr_strap,
  input  logic              reg_sel,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              loopback_en,
  output logic              speed_100,
  output logic              autoneg_en,
  output logic              low_power,
  output logic              isolate,
  output logic              full_duplex,
  output logic              col_test,
  output logic              an_restart_req,
  input  logic              an_restart_ack,
  output logic              restore_defaults
);
  logic  busy;
  logic  accept;
  logic  sw_start;
  logic  mode_wr;
  logic  an_set;
  logic  an_bit;
  logic  restore_q;
  mode_t mode_q;

  assign accept   = reg_sel && reg_wr_en && !busy;
  assign sw_start = accept && reg_wr_data[B_SWRST];
  assign mode_wr  = accept && !reg_wr_data[B_SWRST];
  assign an_set   = mode_wr && reg_wr_data[B_ANRST];

  phy_mgmt_swrst #(.RST_CYCLES(RST_CYCLES)) u_swrst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sw_start),
    .busy  (busy)
  );

  phy_mgmt_anrst #(.WAIT_ACK(WAIT_ACK)) u_anrst (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sw_start),
    .set   (an_set),
    .ack   (an_restart_ack),
    .bit_q (an_bit),
    .req   (an_restart_req)
  );

  phy_mgmt_modes u_modes (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (phy_addr_strap),
    .load_dflt (sw_start),
    .wr        (mode_wr),
    .wr_word   (reg_wr_data),
    .mode_q    (mode_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_q <= 1'b1;
    else        restore_q <= sw_start;
  end

  assign restore_defaults = restore_q;
  assign reg_rd_data      = reg_sel ? word_from_mode(mode_q, busy, an_bit) : '0;

  assign loopback_en = mode_q.loopback;
  assign speed_100   = mode_q.speed_100;
  assign autoneg_en  = mode_q.an_enable;
  assign low_power   = mode_q.low_power;
  assign isolate     = mode_q.isolate;
  assign full_duplex = mode_q.full_duplex;
  assign col_test    = mode_q.col_test;

  assert_swrst_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr_en && reg_wr_data[B_SWRST] && !busy) |=>
      (mode_q == mode_default(phy_addr_strap)) && !an_bit && busy);
  assert_drop_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q) && !an_restart_req);
  assert_req_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_req |-> $past(reg_sel && reg_wr_en && !busy &&
                             reg_wr_data[B_ANRST] && !reg_wr_data[B_SWRST]));
  assert_restore_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr_en && reg_wr_data[B_SWRST] && !busy) |=> restore_defaults);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[RSVD_W-1:0] == '0);
endmodule

// File: tb/phy_mgmt_ctrl_tb.sv
module phy_mgmt_ctrl_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = 5'd0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic        ack = 1'b0;
  logic [15:0] rdata;
  logic        o_loop, o_spd, o_anen, o_lp, o_iso, o_dup, o_col, o_req, o_rest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [15:0] m_mode;   // only bits 14..10, 8, 7 used
  bit          m_busy, m_an, m_req, m_restore;
  int          m_cnt;
  localparam logic [15:0] MODE_MASK = 16'h7D80;

  always #4 clk = ~clk;

  phy_mgmt_ctrl #(.RST_CYCLES(N), .WAIT_ACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .phy_addr_strap(strap),
    .reg_sel(sel), .reg_wr_en(we), .reg_wr_data(wdata), .reg_rd_data(rdata),
    .loopback_en(o_loop), .speed_100(o_spd), .autoneg_en(o_anen), .low_power(o_lp),
    .isolate(o_iso), .full_duplex(o_dup), .col_test(o_col),
    .an_restart_req(o_req), .an_restart_ack(ack), .restore_defaults(o_rest)
  );

  function automatic logic [15:0] dflt_word(input logic [4:0] s);
    return 16'h3000 | ((s == 5'd0) ? 16'h0400 : 16'h0000);
  endfunction

  function automatic logic [15:0] model_word();
    return (m_mode & MODE_MASK) | (m_busy ? 16'h8000 : 16'h0) | (m_an ? 16'h0200 : 16'h0);
  endfunction

  task automatic model_hw_reset();
    m_mode = dflt_word(strap);
    m_busy = 0; m_an = 0; m_req = 0; m_restore = 1; m_cnt = 0;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model step on each rising edge
  always @(posedge clk) begin
    if (!rst_n) model_hw_reset();
    else begin
      bit w;
      w = sel && we && !m_busy;
      m_restore = w && wdata[15];
      m_req = 0;
      if (m_busy) begin
        if (m_cnt == N - 1) m_busy = 0;
        else m_cnt++;
      end
      if (m_an && ack) m_an = 0;
      if (w) begin
        if (wdata[15]) begin
          m_busy = 1; m_cnt = 0; m_mode = dflt_word(strap); m_an = 0;
        end else begin
          m_mode = wdata & MODE_MASK;
          if (wdata[9]) begin m_an = 1; m_req = 1; end
        end
      end
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!rst_n) model_hw_reset();
    check("R2 read word", rdata, sel ? model_word() : 16'h0);
    check("R2 mode outputs", {9'd0, o_loop, o_spd, o_anen, o_lp, o_iso, o_dup, o_col},
          {9'd0, m_mode[14], m_mode[13], m_mode[12], m_mode[11], m_mode[10], m_mode[8], m_mode[7]});
    check("R7 restart request", {15'd0, o_req}, {15'd0, m_req});
    check("R9 restore pulse", {15'd0, o_rest}, {15'd0, m_restore});
  end

  task automatic write_reg(input logic [15:0] d);
    @(negedge clk);
    sel = 1; we = 1; wdata = d;
    @(negedge clk);
    we = 0; wdata = 16'h0;
  endtask

  task automatic read_now(input string tag, input logic [15:0] exp);
    sel = 1;
    #3;
    check(tag, rdata, exp);
  endtask

  task automatic hw_reset(input logic [4:0] s);
    @(negedge clk);
    rst_n = 0; sel = 0; we = 0; ack = 0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    check("R9 restore after hw reset", {15'd0, o_rest}, 16'd1);
    @(negedge clk);
  endtask

  initial begin
    model_hw_reset();
    hw_reset(5'd0);
    read_now("R1 default strap 0", 16'h3400);
    check("R9 restore low after first cycle", {15'd0, o_rest}, 16'd0);

    write_reg(16'h417F);
    read_now("R3 reserved ignored", 16'h4100);
    write_reg(16'h3C80);
    read_now("R2 mode write", 16'h3C80);
    check("R2 low power out", {15'd0, o_lp}, 16'd1);

    // R10: unselected or not-enabled writes
    @(negedge clk); sel = 0; we = 1; wdata = 16'h4000;
    #3; check("R11 read zero unselected", rdata, 16'h0);
    @(negedge clk); sel = 1; we = 0; wdata = 16'h4000;
    @(negedge clk); wdata = 16'h0;
    read_now("R10 ignored writes", 16'h3C80);

    // R7 / R8: restart with acknowledge
    write_reg(16'h3E80);
    #3; check("R7 request pulse", {15'd0, o_req}, 16'd1);
    check("R8 bit9 set", rdata, 16'h3E80);
    repeat (3) @(negedge clk);
    read_now("R8 bit9 held", 16'h3E80);
    check("R7 request single", {15'd0, o_req}, 16'd0);
    ack = 1; @(negedge clk); ack = 0;
    read_now("R8 bit9 cleared by ack", 16'h3C80);
    write_reg(16'h3C80);
    #3; check("R7 no request on zero", {15'd0, o_req}, 16'd0);

    // R4 / R5 / R6 / R9: software reset
    write_reg(16'hFFFF);
    #3; check("R9 restore after sw reset", {15'd0, o_rest}, 16'd1);
    read_now("R5 defaults in reset", 16'hB400);
    for (int i = 0; i < N; i++) begin
      if (i == 4) begin
        we = 1; wdata = 16'h4100;
        @(negedge clk); we = 0; wdata = 16'h0;
        #3; check("R6 write dropped", rdata, 16'hB400);
      end else if (i != 5) begin
        check("R4 bit15 during reset", {15'd0, rdata[15]}, 16'd1);
        @(negedge clk); #3;
      end else begin
        @(negedge clk); #3;
      end
    end
    check("R4 bit15 cleared", rdata, 16'h3400);

    hw_reset(5'd3);
    read_now("R1 default strap nonzero", 16'h3000);
    write_reg(16'h6580);
    write_reg(16'h8000);
    read_now("R5 defaults strap nonzero", 16'hB000);
    repeat (N + 2) @(negedge clk);

    // Mixed traffic, compared against the model each cycle
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      sel   = ($urandom % 4) != 0;
      we    = ($urandom % 3) == 0;
      wdata = 16'($urandom) & 16'h7FFF;
      if (($urandom % 40) == 0) wdata[15] = 1'b1;
      ack   = ($urandom % 5) == 0;
    end
    @(negedge clk); sel = 0; we = 0; ack = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule